// File: doc/BRIEF.md
# Chained Exit-Target Predictor Cache

This block predicts control flow one whole extended basic block at a time. Each prediction is keyed by the address at which a block is entered. It holds the address the block is expected to leave to, and the number of instruction bytes that precede that exit. Because a multi-way block keeps a single entry, a wrong guess costs one recovery at most. Each prediction that hits is issued as a prefetch request. Its target then becomes the key of the next lookup, so a short chain of requests runs ahead of execution.

The core reports actual exits on the update port, and an update is written into the cache right away. The update also throws away the chain in flight and starts a new chain from the corrected target. Storage is a set-associative main array with LRU replacement, plus a small fully associative victim buffer that is searched in parallel with it. A separate load port can fill entries from a table held in memory. That port opens only when a phase-change pulse arrives.

Start requests, prefetch requests and load beats use valid/ready handshakes. A prefetch request stays on the port, unchanged, until it is accepted. While it waits, the chain stalls. A load beat is held off by deasserting its ready whenever the single write port is in use. The phase-change pulse and the update port are plain inputs, and an update is always accepted.

Top module: `exit_chain_predictor`

## Requirements
- R1: After reset, pf_valid and bl_ready are 0 and start_ready is 1.
- R2: Address bits [7:2] select the set and bits [31:8] identify the block, so bits [1:0] of a key are ignored. A hit returns the stored block address on pf_addr, and its target and byte length on pf_target and pf_len.
- R3: When a start is accepted in cycle c, the first prefetch request is valid in cycle c+3. When an update is presented in cycle c, the request for its target is valid in cycle c+3.
- R4: A lookup that misses produces no prefetch request and ends the chain. start_ready returns to 1, and it is 1 only while no request is pending.
- R5: When a request is accepted, its target becomes the next lookup key, and that request follows three cycles later. A chain issues at most CHAIN_MAX requests, which is 4 by default.
- R6: While pf_ready is 0, a pending request keeps pf_valid high, and pf_addr, pf_target and pf_len hold their values.
- R7: An update writes block, target and length. It replaces an existing entry for the same block, or else takes the LRU way of the set. It also flushes the chain and restarts it from upd_target.
- R8: A valid entry displaced from the main array moves into the victim buffer and can still be predicted from there. A victim hit is swapped back into the main array.
- R9: bl_ready can be 1 only after a phase_go pulse and until a beat with bl_last has been accepted. An accepted beat is written as an entry.
- R10: In a cycle with an update, bl_ready is 0 and the update is written. The stalled beat is taken in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request to begin a chain |
| start_ready | output | 1 | Chain idle, start can be taken |
| start_addr | input | 32 | Entry address of the first block |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Prefetch request accepted |
| pf_addr | output | 32 | Block entry address to fetch from |
| pf_target | output | 32 | Predicted exit target |
| pf_len | output | 8 | Bytes to fetch before the exit |
| upd_valid | input | 1 | Core reports a corrected exit |
| upd_block | input | 32 | Block entry address of the report |
| upd_target | input | 32 | Observed exit target |
| upd_len | input | 8 | Observed byte length |
| phase_go | input | 1 | Phase-change pulse opening the load window |
| bl_valid | input | 1 | Load beat valid |
| bl_ready | output | 1 | Load beat accepted |
| bl_last | input | 1 | Final beat of the load |
| bl_block | input | 32 | Loaded block address |
| bl_target | input | 32 | Loaded target |
| bl_len | input | 8 | Loaded byte length |

## Verification
An update from the core and a bulk-load beat can arrive in the same cycle and compete for the one write port. The bench opens a load window and then drives an update and a load beat into the same set in one cycle. It checks that bl_ready is low while the update is present, and high once the update is gone. Both entries must be predicted correctly afterwards. A second overlap is an update arriving while a prefetch request is held by back-pressure. That request must be dropped, and a request for the corrected target must appear three cycles later.

// File: rtl/epc_pkg.sv
package epc_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;
  localparam int OFF_W  = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LEN_W-1:0]  len_t;

  typedef struct packed {
    addr_t block;
    addr_t target;
    len_t  len;
  } pred_t;
endpackage

// File: rtl/epc_store.sv
module epc_store
  import epc_pkg::*;
#(
  parameter int SETS    = 64,
  parameter int WAYS    = 4,
  parameter int VICTIMS = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t lk_key,
  input  logic  lk_touch,
  output logic  lk_hit,
  output logic  lk_from_victim,
  output pred_t lk_pred,
  input  logic  wr_en,
  input  pred_t wr_pred
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int VIC_W = (VICTIMS > 1) ? $clog2(VICTIMS) : 1;

  logic [WAYS-1:0]  m_vld [SETS];
  pred_t            m_ent [SETS][WAYS];
  logic [WAY_W-1:0] m_age [SETS][WAYS];
  logic [VICTIMS-1:0] v_vld;
  pred_t            v_ent [VICTIMS];
  logic [VIC_W-1:0] v_ptr;

  function automatic logic same_blk(addr_t a, addr_t b);
    return a[ADDR_W-1:OFF_W] == b[ADDR_W-1:OFF_W];
  endfunction

  // lookup side
  logic [IDX_W-1:0] lk_set;
  logic             m_hit, v_hit;
  logic [WAY_W-1:0] m_way;
  logic [VIC_W-1:0] v_slot;

  assign lk_set = lk_key[OFF_W +: IDX_W];

  always_comb begin
    m_hit = 1'b0;
    m_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (m_vld[lk_set][w] && same_blk(m_ent[lk_set][w].block, lk_key)) begin
        m_hit = 1'b1;
        m_way = WAY_W'(w);
      end
    end
    v_hit  = 1'b0;
    v_slot = '0;
    for (int v = 0; v < VICTIMS; v++) begin
      if (v_vld[v] && same_blk(v_ent[v].block, lk_key)) begin
        v_hit  = 1'b1;
        v_slot = VIC_W'(v);
      end
    end
  end

  assign lk_hit         = m_hit | v_hit;
  assign lk_from_victim = !m_hit && v_hit;
  assign lk_pred        = m_hit ? m_ent[lk_set][m_way] : v_ent[v_slot];

  // write side
  logic [IDX_W-1:0] w_set;
  logic             w_hit, w_vhit, evict;
  logic [WAY_W-1:0] w_way, lru_way, wway;
  logic [VIC_W-1:0] w_vslot;

  assign w_set = wr_pred.block[OFF_W +: IDX_W];

  always_comb begin
    w_hit   = 1'b0;
    w_way   = '0;
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (m_vld[w_set][w] && same_blk(m_ent[w_set][w].block, wr_pred.block)) begin
        w_hit = 1'b1;
        w_way = WAY_W'(w);
      end
      if (m_age[w_set][w] == WAY_W'(WAYS-1)) lru_way = WAY_W'(w);
    end
    w_vhit  = 1'b0;
    w_vslot = '0;
    for (int v = 0; v < VICTIMS; v++) begin
      if (v_vld[v] && same_blk(v_ent[v].block, wr_pred.block)) begin
        w_vhit  = 1'b1;
        w_vslot = VIC_W'(v);
      end
    end
  end

  assign wway  = w_hit ? w_way : lru_way;
  assign evict = wr_en && !w_hit && m_vld[w_set][lru_way];

  // recency update: a write wins over a lookup touch in the same cycle
  logic             t_do;
  logic [IDX_W-1:0] t_set;
  logic [WAY_W-1:0] t_way;

  assign t_do  = wr_en | (lk_touch & m_hit);
  assign t_set = wr_en ? w_set : lk_set;
  assign t_way = wr_en ? wway : m_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        m_vld[s] <= '0;
        for (int w = 0; w < WAYS; w++) m_age[s][w] <= WAY_W'(w);
      end
      v_vld <= '0;
      v_ptr <= '0;
    end else begin
      if (wr_en) begin
        m_vld[w_set][wway] <= 1'b1;
        if (w_vhit) v_vld[w_vslot] <= 1'b0;
        if (evict) begin
          v_vld[v_ptr] <= 1'b1;
          v_ptr <= (v_ptr == VIC_W'(VICTIMS-1)) ? '0 : v_ptr + 1'b1;
        end
      end
      if (t_do) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == t_way)
            m_age[t_set][w] <= '0;
          else if (m_age[t_set][w] < m_age[t_set][t_way])
            m_age[t_set][w] <= m_age[t_set][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) m_ent[w_set][wway] <= wr_pred;
    if (evict) v_ent[v_ptr] <= m_ent[w_set][lru_way];
  end
endmodule

// File: rtl/epc_chain.sv
module epc_chain
  import epc_pkg::*;
#(
  parameter int CHAIN_MAX = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_valid,
  output logic  start_ready,
  input  addr_t start_addr,
  input  logic  upd_valid,
  input  addr_t upd_target,
  output logic  pf_valid,
  input  logic  pf_ready,
  output pred_t pf_pred,
  output logic  lk_en,
  output addr_t lk_key,
  input  logic  lk_hit,
  input  logic  lk_from_victim,
  input  pred_t lk_pred,
  output logic  swap_req
);
  localparam int DEP_W = $clog2(CHAIN_MAX + 1);

  logic             s1_v, s2_v;
  addr_t            s1_key;
  pred_t            s2_pred;
  logic [DEP_W-1:0] depth;

  assign start_ready = !(s1_v || s2_v || pf_valid) && !upd_valid;
  assign lk_en       = s1_v;
  assign lk_key      = s1_key;
  assign swap_req    = s1_v && lk_from_victim && !upd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s2_v     <= 1'b0;
      pf_valid <= 1'b0;
      s1_key   <= '0;
      s2_pred  <= '0;
      pf_pred  <= '0;
      depth    <= '0;
    end else if (upd_valid) begin
      s1_v     <= 1'b1;
      s1_key   <= upd_target;
      s2_v     <= 1'b0;
      pf_valid <= 1'b0;
      depth    <= DEP_W'(1);
    end else begin
      s1_v    <= 1'b0;
      s2_v    <= s1_v && lk_hit;
      s2_pred <= lk_pred;
      if (start_valid && start_ready) begin
        s1_v   <= 1'b1;
        s1_key <= start_addr;
        depth  <= DEP_W'(1);
      end
      if (s2_v) begin
        pf_valid <= 1'b1;
        pf_pred  <= s2_pred;
      end else if (pf_valid && pf_ready) begin
        pf_valid <= 1'b0;
        if (depth < DEP_W'(CHAIN_MAX)) begin
          s1_v   <= 1'b1;
          s1_key <= pf_pred.target;
          depth  <= depth + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/epc_bulk.sv
module epc_bulk (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_go,
  input  logic bl_valid,
  input  logic bl_last,
  input  logic port_taken,
  output logic bl_ready,
  output logic bl_take
);
  logic open_q;

  assign bl_ready = open_q && !port_taken;
  assign bl_take  = bl_valid && bl_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)
      open_q <= 1'b0;
    else if (phase_go)
      open_q <= 1'b1;
    else if (bl_take && bl_last)
      open_q <= 1'b0;
  end
endmodule

// File: rtl/exit_chain_predictor.sv
module exit_chain_predictor
  import epc_pkg::*;
#(
  parameter int SETS      = 64,
  parameter int WAYS      = 4,
  parameter int VICTIMS   = 4,
  parameter int CHAIN_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [ADDR_W-1:0] pf_target,
  output logic [LEN_W-1:0]  pf_len,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_block,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic [LEN_W-1:0]  upd_len,
  input  logic              phase_go,
  input  logic              bl_valid,
  output logic              bl_ready,
  input  logic              bl_last,
  input  logic [ADDR_W-1:0] bl_block,
  input  logic [ADDR_W-1:0] bl_target,
  input  logic [LEN_W-1:0]  bl_len
);
  logic  lk_en, lk_hit, lk_from_victim, swap_req, bl_take, wr_en;
  addr_t lk_key;
  pred_t lk_pred, pf_pred, wr_pred;

  // single write port: update, then victim swap-back, then bulk beat
  assign wr_en   = upd_valid | swap_req | bl_take;
  assign wr_pred = upd_valid ? pred_t'{upd_block, upd_target, upd_len} :
                   swap_req  ? lk_pred :
                               pred_t'{bl_block, bl_target, bl_len};

  assign pf_addr   = pf_pred.block;
  assign pf_target = pf_pred.target;
  assign pf_len    = pf_pred.len;

  epc_store #(.SETS(SETS), .WAYS(WAYS), .VICTIMS(VICTIMS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_key(lk_key), .lk_touch(lk_en),
    .lk_hit(lk_hit), .lk_from_victim(lk_from_victim), .lk_pred(lk_pred),
    .wr_en(wr_en), .wr_pred(wr_pred)
  );

  epc_chain #(.CHAIN_MAX(CHAIN_MAX)) u_chain (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready), .start_addr(start_addr),
    .upd_valid(upd_valid), .upd_target(upd_target),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_pred(pf_pred),
    .lk_en(lk_en), .lk_key(lk_key), .lk_hit(lk_hit),
    .lk_from_victim(lk_from_victim), .lk_pred(lk_pred), .swap_req(swap_req)
  );

  epc_bulk u_bulk (
    .clk(clk), .rst_n(rst_n), .phase_go(phase_go),
    .bl_valid(bl_valid), .bl_last(bl_last),
    .port_taken(upd_valid | swap_req),
    .bl_ready(bl_ready), .bl_take(bl_take)
  );
endmodule

// File: rtl/epc_checker.sv
module epc_checker #(
  parameter int CHAIN_MAX = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_valid,
  input logic        start_ready,
  input logic        pf_valid,
  input logic        pf_ready,
  input logic [31:0] pf_addr,
  input logic [31:0] pf_target,
  input logic [7:0]  pf_len,
  input logic        upd_valid,
  input logic        phase_go,
  input logic        bl_valid,
  input logic        bl_ready,
  input logic        bl_last
);
  logic [7:0] links;

  always_ff @(posedge clk) begin
    if (!rst_n)
      links <= '0;
    else if (upd_valid || (start_valid && start_ready))
      links <= '0;
    else if (pf_valid && pf_ready)
      links <= links + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !pf_valid); // R4
  AST_START_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !pf_valid ##1 !pf_valid); // R3
  AST_CHAIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    links <= 8'(CHAIN_MAX)); // R5
  AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !upd_valid) |=> pf_valid && $stable(pf_addr)
      && $stable(pf_target) && $stable(pf_len)); // R6
  AST_UPD_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !pf_valid); // R7
  AST_WINDOW_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (bl_valid && bl_ready && bl_last && !phase_go) |=> !bl_ready); // R9
  AST_BULK_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> !bl_ready); // R10
endmodule

bind exit_chain_predictor epc_checker #(.CHAIN_MAX(CHAIN_MAX)) u_epc_checker (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
  .pf_target(pf_target), .pf_len(pf_len), .upd_valid(upd_valid),
  .phase_go(phase_go), .bl_valid(bl_valid), .bl_ready(bl_ready), .bl_last(bl_last)
);

// File: tb/exit_chain_predictor_bench.sv
module exit_chain_predictor_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0, start_ready;
  logic [31:0] start_addr = '0;
  logic        pf_valid, pf_ready = 1'b1;
  logic [31:0] pf_addr, pf_target;
  logic [7:0]  pf_len;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_block = '0, upd_target = '0;
  logic [7:0]  upd_len = '0;
  logic        phase_go = 1'b0, bl_valid = 1'b0, bl_ready, bl_last = 1'b0;
  logic [31:0] bl_block = '0, bl_target = '0;
  logic [7:0]  bl_len = '0;

  int checks = 0;
  int errors = 0;
  logic [31:0] rec_addr [16];
  int          rec_cyc  [16];
  int          rec_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  exit_chain_predictor u_exit_chain_predictor (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (16) tick();
  endtask

  task automatic update(input logic [31:0] b, input logic [31:0] t, input logic [7:0] l);
    upd_valid = 1'b1; upd_block = b; upd_target = t; upd_len = l;
    tick();
    upd_valid = 1'b0;
  endtask

  task automatic start(input logic [31:0] a);
    while (!start_ready) tick();
    start_valid = 1'b1; start_addr = a;
    tick();
    start_valid = 1'b0;
  endtask

  task automatic collect(input int cycles);
    rec_n = 0;
    for (int c = 0; c < cycles; c++) begin
      if (pf_valid && pf_ready && rec_n < 16) begin
        rec_addr[rec_n] = pf_addr; rec_cyc[rec_n] = c; rec_n++;
      end
      tick();
    end
  endtask

  task automatic expect_hit(input logic [31:0] a, input logic [31:0] exp_blk,
                            input logic [31:0] exp_t, input logic [7:0] exp_l, input string req);
    start(a);
    tick(); tick();
    check(pf_valid == 1'b1, req, "hit valid", 32'(pf_valid), 32'd1);
    check(pf_addr == exp_blk, req, "hit block", pf_addr, exp_blk);
    check(pf_target == exp_t, req, "hit target", pf_target, exp_t);
    check(pf_len == exp_l, req, "hit len", 32'(pf_len), 32'(exp_l));
    settle();
  endtask

  task automatic t_reset();
    check(pf_valid == 1'b0, "R1", "pf_valid", 32'(pf_valid), 32'd0);
    check(bl_ready == 1'b0, "R1", "bl_ready", 32'(bl_ready), 32'd0);
    check(start_ready == 1'b1, "R1", "start_ready", 32'(start_ready), 32'd1);
  endtask

  task automatic t_cold_miss();
    bit seen = 1'b0;
    start(32'h1000_0010);
    repeat (8) begin
      if (pf_valid) seen = 1'b1;
      tick();
    end
    check(!seen, "R4", "miss produced request", 32'(seen), 32'd0);
    check(start_ready == 1'b1, "R4", "start_ready after miss", 32'(start_ready), 32'd1);
  endtask

  task automatic t_update_latency();
    update(32'h1000_0010, 32'h1000_0020, 8'd20);
    settle();
    start(32'h1000_0010);
    check(pf_valid == 1'b0, "R3", "valid at c+1", 32'(pf_valid), 32'd0);
    tick();
    check(pf_valid == 1'b0, "R3", "valid at c+2", 32'(pf_valid), 32'd0);
    tick();
    check(pf_valid == 1'b1, "R3", "valid at c+3", 32'(pf_valid), 32'd1);
    check(pf_target == 32'h1000_0020, "R7", "allocated target", pf_target, 32'h1000_0020);
    check(pf_len == 8'd20, "R2", "length", 32'(pf_len), 32'd20);
    settle();
    expect_hit(32'h1000_0013, 32'h1000_0010, 32'h1000_0020, 8'd20, "R2");
    update(32'h1000_0010, 32'h1000_0030, 8'd12);
    settle();
    expect_hit(32'h1000_0010, 32'h1000_0010, 32'h1000_0030, 8'd12, "R7");
  endtask

  task automatic t_chain();
    for (int k = 0; k < 6; k++) begin
      update(32'h2000_0040 + 32'(4*k), 32'h2000_0040 + 32'(4*(k+1)), 8'(8+k));
      settle();
    end
    start(32'h2000_0040);
    collect(24);
    check(rec_n == 4, "R5", "chain length", 32'(rec_n), 32'd4);
    for (int k = 0; k < 4; k++)
      if (k < rec_n)
        check(rec_addr[k] == 32'h2000_0040 + 32'(4*k), "R5", "chain order",
              rec_addr[k], 32'h2000_0040 + 32'(4*k));
    if (rec_n > 1)
      check(rec_cyc[1] - rec_cyc[0] == 3, "R5", "link spacing",
            32'(rec_cyc[1] - rec_cyc[0]), 32'd3);
    start(32'h2000_0050);
    collect(24);
    check(rec_n == 2, "R4", "chain stops on miss", 32'(rec_n), 32'd2);
  endtask

  task automatic t_backpressure();
    bit held = 1'b1;
    pf_ready = 1'b0;
    start(32'h2000_0040);
    tick(); tick();
    repeat (5) begin
      if (!(pf_valid && pf_addr == 32'h2000_0040 && pf_len == 8'd8)) held = 1'b0;
      tick();
    end
    check(held, "R6", "request held", pf_addr, 32'h2000_0040);
    pf_ready = 1'b1;
    collect(12);
    check(rec_n >= 2 && rec_addr[1] == 32'h2000_0044, "R6", "next after release",
          rec_addr[1], 32'h2000_0044);
    settle();
  endtask

  task automatic t_flush();
    update(32'h3000_0080, 32'h3000_0090, 8'd5);
    settle();
    pf_ready = 1'b0;
    start(32'h2000_0040);
    tick(); tick();
    check(pf_valid == 1'b1, "R6", "pending before update", 32'(pf_valid), 32'd1);
    update(32'h2000_0040, 32'h3000_0080, 8'd7);
    check(pf_valid == 1'b0, "R7", "flushed", 32'(pf_valid), 32'd0);
    tick();
    check(pf_valid == 1'b0, "R3", "restart c+2", 32'(pf_valid), 32'd0);
    tick();
    check(pf_valid == 1'b1 && pf_addr == 32'h3000_0080, "R7", "restart block",
          pf_addr, 32'h3000_0080);
    check(pf_target == 32'h3000_0090, "R7", "restart target", pf_target, 32'h3000_0090);
    pf_ready = 1'b1;
    settle();
  endtask

  task automatic t_victim();
    for (int k = 1; k <= 5; k++) begin
      update(32'h4000_0000 + 32'(k*256), 32'h6000_00F0 + 32'(k*256), 8'(40+k));
      settle();
    end
    expect_hit(32'h4000_0100, 32'h4000_0100, 32'h6000_01F0, 8'd41, "R8");
    expect_hit(32'h4000_0200, 32'h4000_0200, 32'h6000_02F0, 8'd42, "R8");
    expect_hit(32'h4000_0500, 32'h4000_0500, 32'h6000_05F0, 8'd45, "R8");
    expect_hit(32'h4000_0100, 32'h4000_0100, 32'h6000_01F0, 8'd41, "R8");
  endtask

  task automatic t_bulk();
    check(bl_ready == 1'b0, "R9", "closed before trigger", 32'(bl_ready), 32'd0);
    phase_go = 1'b1; tick(); phase_go = 1'b0;
    check(bl_ready == 1'b1, "R9", "open after trigger", 32'(bl_ready), 32'd1);
    bl_valid = 1'b1; bl_block = 32'h7000_0200; bl_target = 32'h7000_0300; bl_len = 8'd33;
    bl_last = 1'b0;
    tick();
    bl_block = 32'h7000_0204; bl_target = 32'h7000_0304; bl_len = 8'd34; bl_last = 1'b1;
    tick();
    bl_valid = 1'b0; bl_last = 1'b0;
    check(bl_ready == 1'b0, "R9", "closed after last", 32'(bl_ready), 32'd0);
    expect_hit(32'h7000_0200, 32'h7000_0200, 32'h7000_0300, 8'd33, "R9");
    expect_hit(32'h7000_0204, 32'h7000_0204, 32'h7000_0304, 8'd34, "R9");
  endtask

  task automatic t_collision();
    phase_go = 1'b1; tick(); phase_go = 1'b0;
    upd_valid = 1'b1; upd_block = 32'h7100_0400; upd_target = 32'h7100_0500; upd_len = 8'd40;
    bl_valid = 1'b1; bl_block = 32'h7200_0400; bl_target = 32'h7200_0600; bl_len = 8'd41;
    bl_last = 1'b1;
    #1;
    check(bl_ready == 1'b0, "R10", "bulk stalled by update", 32'(bl_ready), 32'd0);
    tick();
    upd_valid = 1'b0;
    #1;
    check(bl_ready == 1'b1, "R10", "bulk ready after update", 32'(bl_ready), 32'd1);
    tick();
    bl_valid = 1'b0; bl_last = 1'b0;
    check(bl_ready == 1'b0, "R10", "beat taken once", 32'(bl_ready), 32'd0);
    settle();
    expect_hit(32'h7100_0400, 32'h7100_0400, 32'h7100_0500, 8'd40, "R10");
    expect_hit(32'h7200_0400, 32'h7200_0400, 32'h7200_0600, 8'd41, "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_cold_miss();
    t_update_latency();
    t_chain();
    t_backpressure();
    t_flush();
    t_victim();
    t_bulk();
    t_collision();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule